// File: doc/BRIEF.md
# Receive Line Status Keeper

This block sits between a serial receive shifter and a host register port. Each character the shifter delivers comes with two error flags, a bad stop bit (framing) and a bad parity bit. The block stores the character and its flags. It presents a one-byte line status word and a receive data word to the host. The host reads them through a simple read strobe with a one-bit address.

Two storage modes are available. In single-buffer mode there is one holding register, and a newer character replaces an unread one. In queue mode a DEPTH-entry first-in first-out store holds the characters, and each entry keeps its own framing and parity tags. The framing and parity bits then describe only the character at the head of the queue. The overrun bit is sticky in both modes. A status read clears it, together with the framing and parity bits.

Top module: `rx_line_status`

## Requirements
- R1: After reset the block is in single-buffer mode with no stored character, and data_ready, frame_err, parity_err and overrun are all 0.
- R2: The status word is {4'b0000, frame_err, parity_err, overrun, data_ready}, so bit 3 is framing, bit 2 is parity, bit 1 is overrun and bit 0 is data ready. data_ready is 1 exactly while at least one character is stored.
- R3: In single-buffer mode an arrival (rx_valid=1) loads the holding register and a data read empties it. Arriving framing and parity flags set sticky frame_err and parity_err bits.
- R4: In single-buffer mode, an arrival while the holding register is full, without a data read in the same cycle, replaces the stored character and sets overrun.
- R5: In queue mode characters are returned in arrival order, and each data read removes the head. An arrival and a data read may happen in the same cycle.
- R6: In queue mode an arrival while all DEPTH entries are full, without a data read in the same cycle, is discarded and sets overrun. The stored entries are kept.
- R7: In queue mode frame_err and parity_err show the tags of the head entry, not those of the latest arrival.
- R8: A status read (rd_en=1, rd_addr=1) clears frame_err, parity_err and overrun after the clock edge. In queue mode the clear applies to the current head only, and a later head shows its own tags.
- R9: When an error event and a status read fall in the same cycle, the event wins and its bit reads 1 afterwards.
- R10: A change of fifo_mode empties both stores and clears all status bits at the next edge. An arrival in that cycle is dropped.
- R11: rd_data is combinational: address 1 gives the status word, and address 0 gives the head character, or 0 when nothing is stored. Reads change state only when rd_en=1, at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects queue mode, 0 selects single-buffer mode |
| rx_valid | input | 1 | A received character is presented this cycle |
| rx_data | input | DATA_W | Received character |
| rx_frame_err | input | 1 | Character had no valid stop bit |
| rx_parity_err | input | 1 | Character had a wrong parity bit |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 1 | 0 = receive data, 1 = line status |
| rd_data | output | max(DATA_W,8) | Read data |
| data_ready | output | 1 | Status bit 0 |
| overrun | output | 1 | Status bit 1 |
| parity_err | output | 1 | Status bit 2 |
| frame_err | output | 1 | Status bit 3 |

## Verification
The bench builds the block with DEPTH=4 and DATA_W=8. A four-entry queue fills, wraps and overflows within a handful of cycles, so every fill level from empty to two beyond full can be swept. Each level uses an arithmetic pattern of data and error tags, and a status read and a data read are made at every step of draining. The single-buffer mode is swept over all four error-flag combinations. Same-cycle collisions are driven on purpose: arrival with data read, arrival with status read, a pop while full, and a mode change with data stored.

// File: rtl/rx_line_status.sv
module rx_line_status #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [((DATA_W > 8) ? DATA_W : 8)-1:0] rd_data,
  output logic              data_ready,
  output logic              overrun,
  output logic              parity_err,
  output logic              frame_err
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int RD_W = (DATA_W > 8) ? DATA_W : 8;

  logic              mode_q;
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0]  mem_fe, mem_pe;
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;
  logic              ack_q;
  logic [DATA_W-1:0] hold_d;
  logic              hold_full, s_fe, s_pe, ov_q;

  wire flush    = fifo_mode != mode_q;
  wire rd_dat   = rd_en && !rd_addr;
  wire rd_stat  = rd_en && rd_addr;
  wire q_empty  = cnt == '0;
  wire q_full   = cnt == CW'(DEPTH);
  wire q_pop    = !flush && mode_q && rd_dat && !q_empty;
  wire q_push   = !flush && mode_q && rx_valid && (!q_full || q_pop);
  wire q_ovr    = !flush && mode_q && rx_valid && q_full && !q_pop;
  wire h_pop    = !flush && !mode_q && rd_dat && hold_full;
  wire h_load   = !flush && !mode_q && rx_valid;
  wire h_ovr    = h_load && hold_full && !h_pop;
  wire new_head = q_pop || (q_push && q_empty);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (q_push) begin
      mem_d[wp]  <= rx_data;
      mem_fe[wp] <= rx_frame_err;
      mem_pe[wp] <= rx_parity_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      ack_q <= 1'b0;
      hold_d <= '0;
      hold_full <= 1'b0;
      s_fe <= 1'b0;
      s_pe <= 1'b0;
      ov_q <= 1'b0;
    end else if (flush) begin
      mode_q <= fifo_mode;
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      ack_q <= 1'b0;
      hold_full <= 1'b0;
      s_fe <= 1'b0;
      s_pe <= 1'b0;
      ov_q <= 1'b0;
    end else begin
      if (q_push) wp <= nxt(wp);
      if (q_pop)  rp <= nxt(rp);
      if (q_push && !q_pop)      cnt <= cnt + 1'b1;
      else if (q_pop && !q_push) cnt <= cnt - 1'b1;

      if (new_head)     ack_q <= 1'b0;
      else if (rd_stat) ack_q <= 1'b1;

      if (h_load) begin
        hold_d <= rx_data;
        hold_full <= 1'b1;
      end else if (h_pop) begin
        hold_full <= 1'b0;
      end

      if (h_load && rx_frame_err)  s_fe <= 1'b1;
      else if (rd_stat)            s_fe <= 1'b0;
      if (h_load && rx_parity_err) s_pe <= 1'b1;
      else if (rd_stat)            s_pe <= 1'b0;

      if (h_ovr || q_ovr) ov_q <= 1'b1;
      else if (rd_stat)   ov_q <= 1'b0;
    end
  end

  wire [DATA_W-1:0] head = mode_q ? mem_d[rp] : hold_d;

  assign data_ready = mode_q ? !q_empty : hold_full;
  assign frame_err  = mode_q ? (!q_empty && mem_fe[rp] && !ack_q) : s_fe;
  assign parity_err = mode_q ? (!q_empty && mem_pe[rp] && !ack_q) : s_pe;
  assign overrun    = ov_q;

  wire [7:0] status = {4'b0000, frame_err, parity_err, overrun, data_ready};

  assign rd_data = rd_addr    ? RD_W'(status) :
                   data_ready ? RD_W'(head)   : '0;
endmodule

module rx_line_status_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int RD_W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fifo_mode,
  input logic            mode_q,
  input logic            rx_valid,
  input logic            rx_frame_err,
  input logic            rd_en,
  input logic            rd_addr,
  input logic [RD_W-1:0] rd_data,
  input logic [CW-1:0]   cnt,
  input logic            data_ready,
  input logic            overrun,
  input logic            parity_err,
  input logic            frame_err
);
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr |-> rd_data[7:4] == 4'b0000);

  a_r8_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr && !rx_valid && fifo_mode == mode_q)
      |=> (!frame_err && !parity_err && !overrun));

  a_r4_single_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !fifo_mode && data_ready && rx_valid && !(rd_en && !rd_addr))
      |=> (overrun && data_ready));

  a_r6_full_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fifo_mode && cnt == CW'(DEPTH) && rx_valid && !(rd_en && !rd_addr))
      |=> (cnt == CW'(DEPTH) && overrun));

  a_r5_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && fifo_mode && rd_en && !rd_addr && cnt != '0 && !rx_valid)
      |=> cnt == $past(cnt) - 1'b1);

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !fifo_mode && rx_valid && rx_frame_err && rd_en && rd_addr)
      |=> frame_err);

  a_r10_mode_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_mode != mode_q)
      |=> (!data_ready && !overrun && !frame_err && !parity_err));
endmodule

bind rx_line_status rx_line_status_chk #(.DEPTH(DEPTH), .CW(CW), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .mode_q(mode_q),
  .rx_valid(rx_valid), .rx_frame_err(rx_frame_err), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .cnt(cnt), .data_ready(data_ready),
  .overrun(overrun), .parity_err(parity_err), .frame_err(frame_err)
);

// File: tb/sim_rx_line_status.sv
module sim_rx_line_status;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_mode = 1'b0, rx_valid = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
  logic rd_en = 1'b0, rd_addr = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [7:0] rd_data;
  logic data_ready, overrun, parity_err, frame_err;

  always #5 clk = ~clk;

  rx_line_status #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .data_ready(data_ready),
    .overrun(overrun), .parity_err(parity_err), .frame_err(frame_err));

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic m_mode, m_full, m_fe, m_pe, m_ov, m_ack;
  logic [7:0] m_hold;
  logic [7:0] q_d [DEPTH];
  logic q_fe [DEPTH];
  logic q_pe [DEPTH];
  int m_cnt;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic e_dr();
    return m_mode ? (m_cnt != 0) : m_full;
  endfunction
  function automatic logic e_fe();
    return m_mode ? (m_cnt != 0 && q_fe[0] && !m_ack) : m_fe;
  endfunction
  function automatic logic e_pe();
    return m_mode ? (m_cnt != 0 && q_pe[0] && !m_ack) : m_pe;
  endfunction

  task automatic compare_outputs();
    chk("R2 data_ready", data_ready, e_dr());
    chk(m_mode ? "R6 overrun" : "R4 overrun", overrun, m_ov);
    chk(m_mode ? "R7 frame_err" : "R3 frame_err", frame_err, e_fe());
    chk(m_mode ? "R7 parity_err" : "R3 parity_err", parity_err, e_pe());
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic f, input logic p,
                      input logic re, input logic ra);
    logic stat, pop, push, hpop, ovr, flush;
    int c0;
    rx_valid = v; rx_data = d; rx_frame_err = f; rx_parity_err = p;
    rd_en = re; rd_addr = ra;
    #1;
    if (ra)
      chk("R2 status word", rd_data, {4'b0000, e_fe(), e_pe(), m_ov, e_dr()});
    else if (re)
      chk(m_mode ? "R5 read data" : "R11 read data", rd_data,
          !e_dr() ? 0 : (m_mode ? q_d[0] : m_hold));
    stat = re && ra;
    flush = fifo_mode != m_mode;
    if (flush) begin
      m_mode = fifo_mode; m_cnt = 0; m_full = 0; m_fe = 0; m_pe = 0; m_ov = 0; m_ack = 0;
    end else if (m_mode) begin
      c0 = m_cnt;
      pop = re && !ra && c0 > 0;
      push = v && (c0 < DEPTH || pop);
      if (pop) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          q_d[i] = q_d[i+1]; q_fe[i] = q_fe[i+1]; q_pe[i] = q_pe[i+1];
        end
        m_cnt--;
      end
      if (push) begin
        q_d[m_cnt] = d; q_fe[m_cnt] = f; q_pe[m_cnt] = p; m_cnt++;
      end
      if (pop || (push && c0 == 0)) m_ack = 0;
      else if (stat) m_ack = 1;
      if (v && c0 == DEPTH && !pop) m_ov = 1;
      else if (stat) m_ov = 0;
    end else begin
      hpop = re && !ra && m_full;
      ovr = v && m_full && !hpop;
      if (v) begin m_hold = d; m_full = 1; end
      else if (hpop) m_full = 0;
      if (v && f) m_fe = 1; else if (stat) m_fe = 0;
      if (v && p) m_pe = 1; else if (stat) m_pe = 0;
      if (ovr) m_ov = 1; else if (stat) m_ov = 0;
    end
    @(posedge clk); #1;
    rx_valid = 0; rd_en = 0; rd_addr = 0; rx_frame_err = 0; rx_parity_err = 0;
    compare_outputs();
  endtask

  task automatic idle(); step(0, 8'h00, 0, 0, 0, 0); endtask
  task automatic arrive(input logic [7:0] d, input logic f, input logic p); step(1, d, f, p, 0, 0); endtask
  task automatic rd_stat(); step(0, 8'h00, 0, 0, 1, 1); endtask
  task automatic rd_dat(); step(0, 8'h00, 0, 0, 1, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_mode = 0; m_full = 0; m_fe = 0; m_pe = 0; m_ov = 0; m_ack = 0; m_cnt = 0; m_hold = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 frame_err", frame_err, 0);
    chk("R1 parity_err", parity_err, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd_addr = 1; #1;
    chk("R1 status word", rd_data, 0);
    rd_addr = 0;

    // single-buffer sweep over all flag combinations (R3, R4, R8, R11)
    for (int e = 0; e < 4; e++) begin
      arrive(8'h30 + 8'(e), e[0], e[1]);
      rd_stat();
      rd_dat();
      rd_dat();                         // empty read returns 0
      arrive(8'h40 + 8'(e), e[1], e[0]);
      arrive(8'h50 + 8'(e), 0, 0);      // overwrite, overrun
      chk("R4 replaced char", rd_data, 8'h50 + 8'(e));
      step(1, 8'h60 + 8'(e), 0, 0, 1, 0); // read and arrival in one cycle
      rd_stat();
      rd_dat();
      idle();
    end
    // R9: error arrival coincides with status read
    arrive(8'h11, 0, 0);
    step(1, 8'h12, 1, 1, 1, 1);
    chk("R9 frame_err survives", frame_err, 1);
    chk("R9 overrun survives", overrun, 1);
    rd_stat();
    rd_dat();

    // R10: mode change with data stored
    arrive(8'h77, 1, 0);
    fifo_mode = 1;
    step(1, 8'h78, 1, 1, 0, 0);
    chk("R10 flushed", data_ready, 0);
    chk("R10 flags cleared", frame_err, 0);

    // queue sweep over every fill level (R5, R6, R7, R8)
    for (int n = 0; n <= DEPTH + 2; n++) begin
      for (int i = 0; i < n; i++)
        arrive(8'(n * 16 + i), (i % 3) == 1, (i % 2) == 1);
      if (n >= DEPTH)
        step(1, 8'hEE, 1, 0, 1, 0);     // pop while full makes room
      for (int k = 0; k < DEPTH + 1; k++) begin
        rd_stat();
        rd_dat();
      end
      rd_stat();
    end
    // R7: head tags, not latest arrival
    arrive(8'hA0, 0, 0);
    arrive(8'hA1, 1, 1);
    chk("R7 head clean", frame_err, 0);
    rd_dat();
    chk("R7 new head framing", frame_err, 1);
    rd_stat();
    chk("R8 head flags cleared", parity_err, 0);
    rd_dat();

    // back to single mode flushes the queue (R10)
    arrive(8'hB0, 1, 1);
    fifo_mode = 0;
    idle();
    chk("R10 back to single empty", data_ready, 0);
    idle();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule